// File: doc/BRIEF.md
# Two-Wire Register Target with Strap-Selected Address

This block is the serial register port of a measurement front end. It listens on an I2C bus at rates up to 400 kHz. SCL and SDA arrive asynchronously and are oversampled in the core clock domain. The block drives SDA only through an open-drain pull-down enable. Two four-level strap inputs pick one of sixteen 7-bit target addresses. A master reaches twelve byte-wide registers through the usual transaction shapes: a pointer byte followed by any number of data bytes to write, or a pointer byte, a repeated START and a read address to fetch a burst.

Ten of the registers are read-only and present five 12-bit conversion results. A sequencer port loads these results, one channel at a time. Each result occupies an even/odd pair: the even byte carries the eight upper bits, and the odd byte carries the low nibble left-aligned. When the high byte is fetched, the low nibble of that pair is frozen in a shadow, so a two-byte burst always returns one coherent sample. The two remaining registers are control bytes. They drive the analog and timing logic next to this block through `ctl1_q` and `ctl2_q`.

Top module: `i2c_regbank_target`

## Requirements
- R1: The 7-bit target address is {3'b111, strap_a1, strap_a0}. The write address byte is therefore 0xE0 + 2*(4*strap_a1 + strap_a0), and the read address byte is one higher. A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R2: An address byte that does not match gets no acknowledge. The rest of that transaction changes no register.
- R3: In a write transaction, the first byte after the address loads the register pointer. Each following data byte is written at the pointer, and the pointer then advances by one. Every byte is acknowledged.
- R4: A read is a write that sets the pointer, then a repeated START with the read address. Bytes come out MSB first from the pointer, which advances after each byte. A master ACK continues the burst. A NACK ends it, and SDA is released after that.
- R5: Result channel k (0..4, loaded when res_we is high and res_sel = k) appears at address 2k as bits 11:4 and at address 2k+1 as {bits 3:0, 4'b0000}. A res_sel value above 4 is ignored.
- R6: After reset, every register reads 0x00 except address 0x08, which reads 0x80. ctl1_q and ctl2_q are 0x00, and SDA is not driven.
- R7: Writes to addresses 0x00 to 0x09 are acknowledged and leave the stored results unchanged.
- R8: Address 0x0B keeps only bits 3 and 2 of a written byte. All other bits read as 0 and drive 0 on ctl2_q.
- R9: Address 0x0A stores a written byte on ctl1_q, except bit 4. When bit 4 is written as 1, it is high on ctl1_q for exactly one clock and then clears by itself, so it reads back as 0.
- R10: Reading an even result address freezes the low nibble of that pair. A following read of the odd address of the same pair returns the frozen nibble, even if the sequencer has reloaded the channel in between. A STOP discards the frozen nibble.
- R11: Addresses 0x0C to 0xFF read as 0x00. Writes to them are acknowledged and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_a1 | input | 2 | Upper address strap level, 0..3 |
| strap_a0 | input | 2 | Lower address strap level, 0..3 |
| res_we | input | 1 | Sequencer load strobe |
| res_sel | input | 3 | Result channel to load, 0..4 |
| res_data | input | 12 | Result value to load |
| ctl1_q | output | 8 | Control byte at address 0x0A |
| ctl2_q | output | 8 | Control byte at address 0x0B |

## Verification
Two events can fall in the same clock edge: a sequencer load of a result channel, and the bus-side capture of that channel's high byte together with its low-nibble shadow. To provoke this, the bench reloads channel 1 on every clock with a value whose low nibble equals the low four bits of its high byte, while two-byte bursts read addresses 0x02 and 0x03. Whichever cycle the capture lands on, the two returned bytes must agree on that nibble. A second pass checks that a STOP between the two reads discards the shadow, so the odd read then returns the newly loaded nibble.

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [2:0]  ADDR_TOP    = 3'b111,
  parameter logic [11:0] TEMP_RESET  = 12'h800,
  parameter logic [7:0]  CTL2_KEEP   = 8'h0C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [1:0]  strap_a1,
  input  logic [1:0]  strap_a0,
  input  logic        res_we,
  input  logic [2:0]  res_sel,
  input  logic [11:0] res_data,
  output logic [7:0]  ctl1_q,
  output logic [7:0]  ctl2_q
);
  localparam int         NRES      = 5;
  localparam logic [2:0] NRES_L    = 3'(NRES);
  localparam logic [7:0] RES_BYTES = 8'(2 * NRES);
  localparam logic [7:0] CTL1_ADR  = RES_BYTES;
  localparam logic [7:0] CTL2_ADR  = RES_BYTES + 8'd1;
  localparam int         LR_BIT    = 4;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKO, S_TX, S_ACKI} st_t;
  typedef enum logic [1:0] {B_ADDR, B_PTR, B_DATA} role_t;

  logic [SYNC_STAGES:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_s, sda_d;
  logic scl_rise, scl_fall, start_c, stop_c;

  st_t         st;
  role_t       role;
  logic [3:0]  cnt;
  logic [7:0]  sh, ptr, rd_byte, ctl1, ctl2;
  logic        rd_mode, m_ack;
  logic [11:0] res_q [NRES];
  logic [3:0]  shadow_lo;
  logic [2:0]  shadow_pair;
  logic        shadow_ok;
  logic        rx_done, addr_hit, wr_fire, ld_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s    = scl_p[SYNC_STAGES-1];
  assign scl_d    = scl_p[SYNC_STAGES];
  assign sda_s    = sda_p[SYNC_STAGES-1];
  assign sda_d    = sda_p[SYNC_STAGES];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  assign rx_done  = (st == S_RX) && scl_fall && (cnt == 4'd8);
  assign addr_hit = (sh[7:1] == {ADDR_TOP, strap_a1, strap_a0});
  assign wr_fire  = rx_done && (role == B_DATA) && !stop_c && !start_c;
  assign ld_fire  = !stop_c && !start_c && scl_fall &&
                    (((st == S_ACKO) && rd_mode) || ((st == S_ACKI) && m_ack));

  assign sda_oe = (st == S_ACKO) || ((st == S_TX) && !sh[7]);
  assign ctl1_q = ctl1;
  assign ctl2_q = ctl2;

  always_comb begin
    rd_byte = 8'h00;
    if (ptr < RES_BYTES) begin
      if (!ptr[0])
        rd_byte = res_q[ptr[3:1]][11:4];
      else if (shadow_ok && (shadow_pair == ptr[3:1]))
        rd_byte = {shadow_lo, 4'h0};
      else
        rd_byte = {res_q[ptr[3:1]][3:0], 4'h0};
    end else if (ptr == CTL1_ADR) begin
      rd_byte = ctl1;
    end else if (ptr == CTL2_ADR) begin
      rd_byte = ctl2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NRES; i++)
        res_q[i] <= (i == NRES - 1) ? TEMP_RESET : 12'h000;
    end else if (res_we && (res_sel < NRES_L)) begin
      res_q[res_sel] <= res_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1 <= 8'h00;
      ctl2 <= 8'h00;
    end else begin
      ctl1[LR_BIT] <= 1'b0;
      if (wr_fire && (ptr == CTL1_ADR)) ctl1 <= sh;
      if (wr_fire && (ptr == CTL2_ADR)) ctl2 <= sh & CTL2_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_lo   <= 4'h0;
      shadow_pair <= 3'd0;
      shadow_ok   <= 1'b0;
    end else if (stop_c) begin
      shadow_ok <= 1'b0;
    end else if (ld_fire && (ptr < RES_BYTES)) begin
      if (!ptr[0]) begin
        shadow_lo   <= res_q[ptr[3:1]][3:0];
        shadow_pair <= ptr[3:1];
        shadow_ok   <= 1'b1;
      end else begin
        shadow_ok <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      role    <= B_ADDR;
      cnt     <= 4'd0;
      sh      <= 8'h00;
      ptr     <= 8'h00;
      rd_mode <= 1'b0;
      m_ack   <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
    end else if (start_c) begin
      st   <= S_RX;
      role <= B_ADDR;
      cnt  <= 4'd0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (rx_done) begin
            case (role)
              B_ADDR: begin
                if (addr_hit) begin
                  st      <= S_ACKO;
                  rd_mode <= sh[0];
                  role    <= B_PTR;
                end else begin
                  st <= S_IDLE;
                end
              end
              B_PTR: begin
                ptr  <= sh;
                role <= B_DATA;
                st   <= S_ACKO;
              end
              default: begin
                ptr <= ptr + 8'd1;
                st  <= S_ACKO;
              end
            endcase
          end
        end
        S_ACKO: begin
          if (scl_fall) begin
            cnt <= 4'd0;
            if (rd_mode) begin
              st  <= S_TX;
              sh  <= rd_byte;
              ptr <= ptr + 8'd1;
            end else begin
              st <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            sh  <= {sh[6:0], 1'b0};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) st <= S_ACKI;
          end
        end
        S_ACKI: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              st  <= S_TX;
              cnt <= 4'd0;
              sh  <= rd_byte;
              ptr <= ptr + 8'd1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       wr_fire,
  input logic [7:0] ptr,
  input logic [7:0] ctl1_q,
  input logic [7:0] ctl2_q
);
  // R9: the latch-release bit never stays high for two clocks
  a_r9_lr_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ctl1_q[4] |=> !ctl1_q[4]);

  // R8: unused control-2 bits stay low
  a_r8_ctl2_spare_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl2_q & 8'hF3) == 8'h00);

  // R4: the pull-down only changes while the bus clock is low
  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R3: each written data byte moves the pointer by one
  a_r3_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ptr == $past(ptr) + 8'd1);
endmodule

bind i2c_regbank_target i2c_regbank_target_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_s   (scl_s),
  .sda_oe  (sda_oe),
  .wr_fire (wr_fire),
  .ptr     (ptr),
  .ctl1_q  (ctl1_q),
  .ctl2_q  (ctl2_q)
);

// File: tb/tb_i2c_regbank_target.sv
module tb_i2c_regbank_target;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0]  a1 = 2'd0, a0 = 2'd0;
  logic        res_we = 1'b0;
  logic [2:0]  res_sel = 3'd0;
  logic [11:0] res_data = 12'h000;
  logic        sda_oe;
  logic [7:0]  ctl1_q, ctl2_q;
  logic        sda_line;

  assign sda_line = m_sda & ~sda_oe;

  i2c_regbank_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a1(a1), .strap_a0(a0), .res_we(res_we), .res_sel(res_sel),
    .res_data(res_data), .ctl1_q(ctl1_q), .ctl2_q(ctl2_q));

  localparam int Q = 10;
  int errors = 0, checks = 0, lr_cnt = 0;
  bit churn = 1'b0, finished = 1'b0;
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] waddr();
    return 8'hE0 + 8'(2 * (4 * int'(a1) + int'(a0)));
  endfunction

  always @(negedge clk) if (rst_n && ctl1_q[4]) lr_cnt++;

  initial begin : churn_drv
    logic [7:0] n;
    n = 8'h00;
    forever begin
      @(negedge clk);
      if (churn) begin
        res_we   = 1'b1;
        res_sel  = 3'd1;
        res_data = {n, n[3:0]};
        n = n + 8'd1;
      end
    end
  end

  initial begin : monitor
    logic [7:0] g, e;
    string t;
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected read byte", g, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(g == e, t, "read byte", g, e);
        end
      end
    end
  end

  task automatic expect_byte(logic [7:0] v, string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic seq_load(logic [2:0] sel, logic [11:0] v);
    @(negedge clk);
    res_we = 1'b1; res_sel = sel; res_data = v;
    @(negedge clk);
    res_we = 1'b0;
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_sda = 1'b0; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_sda = 1'b1; tick(2 * Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = sda_line;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      m_scl = 1'b0;
    end
    tick(Q);
    m_sda = mack ? 1'b0 : 1'b1; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic wr_regs(logic [7:0] p, int n, logic [7:0] d0, logic [7:0] d1, string req);
    logic ack;
    i2c_start();
    send_byte(waddr(), ack);
    check(ack == 1'b0, "R1", "write address ack", ack, 0);
    send_byte(p, ack);
    check(ack == 1'b0, req, "pointer ack", ack, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(i == 0 ? d0 : d1, ack);
      check(ack == 1'b0, req, "data ack", ack, 0);
    end
    i2c_stop();
  endtask

  task automatic rd_regs(logic [7:0] p, int n, bit to_sb, output logic [7:0] b0, output logic [7:0] b1);
    logic ack;
    logic [7:0] b;
    b0 = 8'h00; b1 = 8'h00;
    i2c_start();
    send_byte(waddr(), ack);
    send_byte(p, ack);
    i2c_start();
    send_byte(waddr() | 8'h01, ack);
    check(ack == 1'b0, "R1", "read address ack", ack, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      if (i == 0) b0 = b;
      if (i == 1) b1 = b;
      if (to_sb) got_q.push_back(b);
    end
    tick(4);
    check(sda_oe == 1'b0, "R4", "SDA released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] x0, x1;
    logic ack;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R6: reset state at the ports
    check(ctl1_q == 8'h00, "R6", "ctl1_q after reset", ctl1_q, 0);
    check(ctl2_q == 8'h00, "R6", "ctl2_q after reset", ctl2_q, 0);
    check(sda_oe == 1'b0, "R6", "sda_oe after reset", sda_oe, 0);

    a1 = 2'd2; a0 = 2'd1;
    for (int i = 0; i < 12; i++) expect_byte(i == 8 ? 8'h80 : 8'h00, "R6");
    rd_regs(8'h00, 12, 1'b1, x0, x1);

    // R2: wrong address gets no ack and the following bytes do nothing
    i2c_start();
    send_byte(8'hF0, ack);
    check(ack == 1'b1, "R2", "foreign address nack", ack, 1);
    send_byte(8'h0A, ack);
    send_byte(8'h77, ack);
    i2c_stop();
    check(ctl1_q == 8'h00, "R2", "ctl1_q untouched", ctl1_q, 0);

    // R1: strap decoding at other strap levels
    a1 = 2'd3; a0 = 2'd3;
    i2c_start(); send_byte(8'hFE, ack); i2c_stop();
    check(ack == 1'b0, "R1", "ack at 0xFE for straps 3/3", ack, 0);
    a1 = 2'd0; a0 = 2'd0;
    i2c_start(); send_byte(8'hE0, ack); i2c_stop();
    check(ack == 1'b0, "R1", "ack at 0xE0 for straps 0/0", ack, 0);
    a1 = 2'd1; a0 = 2'd2;
    i2c_start(); send_byte(8'hE8, ack); i2c_stop();
    check(ack == 1'b1, "R1", "no ack at 0xE8 for straps 1/2", ack, 1);
    a1 = 2'd2; a0 = 2'd1;

    // R5: result layout, plus an out-of-range channel that must be ignored
    seq_load(3'd0, 12'hABC);
    seq_load(3'd1, 12'h123);
    seq_load(3'd2, 12'hFED);
    seq_load(3'd3, 12'h008);
    seq_load(3'd4, 12'h7F1);
    seq_load(3'd6, 12'h555);
    expect_byte(8'hAB, "R5"); expect_byte(8'hC0, "R5");
    expect_byte(8'h12, "R5"); expect_byte(8'h30, "R5");
    expect_byte(8'hFE, "R5"); expect_byte(8'hD0, "R5");
    expect_byte(8'h00, "R5"); expect_byte(8'h80, "R5");
    expect_byte(8'h7F, "R5"); expect_byte(8'h10, "R5");
    expect_byte(8'h00, "R5"); expect_byte(8'h00, "R5");
    rd_regs(8'h00, 12, 1'b1, x0, x1);

    // R3 and R8: burst write across both control bytes
    wr_regs(8'h0A, 2, 8'hE5, 8'hFF, "R3");
    check(ctl1_q == 8'hE5, "R3", "ctl1_q after burst", ctl1_q, 8'hE5);
    check(ctl2_q == 8'h0C, "R8", "ctl2_q masked", ctl2_q, 8'h0C);
    expect_byte(8'hE5, "R3"); expect_byte(8'h0C, "R8");
    rd_regs(8'h0A, 2, 1'b1, x0, x1);

    // R9: self-clearing bit
    lr_cnt = 0;
    wr_regs(8'h0A, 1, 8'h3A, 8'h00, "R9");
    check(lr_cnt == 1, "R9", "cycles with bit 4 high", lr_cnt, 1);
    check(ctl1_q == 8'h2A, "R9", "ctl1_q after clear", ctl1_q, 8'h2A);
    expect_byte(8'h2A, "R9");
    rd_regs(8'h0A, 1, 1'b1, x0, x1);

    // R7: read-only results ignore writes
    wr_regs(8'h00, 2, 8'h55, 8'h66, "R7");
    expect_byte(8'hAB, "R7"); expect_byte(8'hC0, "R7");
    rd_regs(8'h00, 2, 1'b1, x0, x1);

    // R11: unused addresses
    expect_byte(8'h2A, "R11"); expect_byte(8'h0C, "R11");
    expect_byte(8'h00, "R11"); expect_byte(8'h00, "R11");
    rd_regs(8'h0A, 4, 1'b1, x0, x1);
    wr_regs(8'h0C, 1, 8'h99, 8'h00, "R11");
    expect_byte(8'h0C, "R11"); expect_byte(8'h00, "R11");
    rd_regs(8'h0B, 2, 1'b1, x0, x1);

    // R10: sequencer reloads every clock while pairs are read
    churn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      rd_regs(8'h02, 2, 1'b0, x0, x1);
      check(x1[7:4] == x0[3:0] && x1[3:0] == 4'h0, "R10", "coherent pair low byte",
            x1, {x0[3:0], 4'h0});
    end
    churn = 1'b0;
    @(negedge clk);
    res_we = 1'b0;

    // R10: STOP discards the shadow
    seq_load(3'd1, 12'h111);
    rd_regs(8'h02, 1, 1'b0, x0, x1);
    check(x0 == 8'h11, "R10", "high byte", x0, 8'h11);
    seq_load(3'd1, 12'h222);
    rd_regs(8'h03, 1, 1'b0, x0, x1);
    check(x0 == 8'h20, "R10", "low byte after STOP", x0, 8'h20);

    tick(20);
    check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule